// File: doc/BRIEF.md
# Post-Access Pointer Index Updater

This block works out the index update that follows a load or store using one of two modified addressing modes. The index pointer shares a 32-bit companion register with a second field. The low half holds the 16-bit index. The high half holds either a step value for bit-reversed traversal or a buffer length for circular traversal. The block takes the mode, the companion register and a 10-bit signed offset. It returns the index to use for the current access and the companion value to write back afterwards. The memory access and the addition of the base address stay with the issuing unit.

In bit-reversed mode the step is added with the carry running from the most significant index bit toward the least. This visits buffer slots in the scrambled order used by radix-2 FFT stages. In circular mode the offset is added to the index. The sum is then folded back into the range from zero up to one below the length. The update logic is combinational. By default one output register stage follows it, and a parameter can remove that stage.

Top module: `ptr_index_update`

## Requirements
- R1: While reset is asserted and on the first sampled cycle after its release with no valid input, `out_valid` is 0 and both data outputs are 0.
- R2: `out_ea_index` equals the incoming companion bits [15:0], zero-extended to 32 bits, in both modes. This is the pre-update index.
- R3: In bit-reversed mode (`in_mode` = 0), the new index in `out_companion[15:0]` is rev(rev(index) + rev(step)) truncated to 16 bits. Here rev mirrors the 16 bits and step is companion bits [31:16].
- R4: In bit-reversed mode, `out_companion[31:16]` equals the incoming step field.
- R5: In circular mode (`in_mode` = 1) with a nonzero length, when index plus the sign-extended offset lies in [0, length), that sum is the new index.
- R6: In circular mode with a nonzero length, a sum at or above the length has the length subtracted once.
- R7: In circular mode with a nonzero length, a negative sum has the length added once.
- R8: In circular mode with a length of zero, the new index is the low 16 bits of the raw sum, with no folding.
- R9: In circular mode, `out_companion[31:16]` equals the incoming length field.
- R10: With the default registered output, every output reflects the input presented one clock earlier, and `out_valid` equals the previous cycle's `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| in_mode | input | 1 | 0 = bit-reversed, 1 = circular |
| in_companion | input | 32 | Companion register: [31:16] step or length, [15:0] index |
| in_offset | input | 10 | Two's complement offset, used in circular mode |
| out_valid | output | 1 | Result present |
| out_ea_index | output | 32 | Zero-extended index for the current access |
| out_companion | output | 32 | Companion value for writeback |

## Verification
The hardest cases to reach are the folding edges of circular mode. These are a sum that lands exactly on the length and a sum that drops exactly to minus one. Reaching them needs the index, the length and the offset sign chosen together. The directed tasks build each edge from explicit operands: an index just below the length with a positive offset, an index near zero with a negative offset, and a zero length with a wrapping sum. For bit-reversed mode, the bench feeds a walking sequence of indices. It also applies random index and step pairs, and each result is compared with a loop-based bit-mirror model.

// File: rtl/ptr_upd_pkg.sv
package ptr_upd_pkg;

    typedef enum logic {
        MODE_BITREV = 1'b0,
        MODE_CIRC   = 1'b1
    } ptr_mode_e;

endpackage

// File: rtl/ptr_bitrev_adder.sv
module ptr_bitrev_adder #(
    parameter int IDX_W = 16
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [IDX_W-1:0] step,
    output logic [IDX_W-1:0] idx_next
);

    logic [IDX_W-1:0] idx_mir;
    logic [IDX_W-1:0] step_mir;
    logic [IDX_W-1:0] sum_mir;

    // mirror both operands, add normally, mirror back
    for (genvar g = 0; g < IDX_W; g++) begin : g_mirror
        assign idx_mir[g]            = idx[IDX_W-1-g];
        assign step_mir[g]           = step[IDX_W-1-g];
        assign idx_next[IDX_W-1-g]   = sum_mir[g];
    end

    assign sum_mir = idx_mir + step_mir;

endmodule

// File: rtl/ptr_circ_wrap.sv
module ptr_circ_wrap #(
    parameter int IDX_W = 16,
    parameter int OFF_W = 10
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [IDX_W-1:0] len,
    input  logic [OFF_W-1:0] off,
    output logic [IDX_W-1:0] idx_next
);

    localparam int SW = IDX_W + 2;

    logic signed [SW-1:0] off_s;
    logic signed [SW-1:0] len_s;
    logic signed [SW-1:0] sum_s;
    logic signed [SW-1:0] fold_s;

    assign off_s = {{(SW-OFF_W){off[OFF_W-1]}}, off};
    assign len_s = {2'b00, len};
    assign sum_s = $signed({2'b00, idx}) + off_s;

    always_comb begin
        if (len == '0) begin
            fold_s = sum_s;
        end else if (sum_s < 0) begin
            fold_s = sum_s + len_s;
        end else if (sum_s >= len_s) begin
            fold_s = sum_s - len_s;
        end else begin
            fold_s = sum_s;
        end
    end

    assign idx_next = fold_s[IDX_W-1:0];

endmodule

// File: rtl/ptr_index_update.sv
module ptr_index_update
    import ptr_upd_pkg::*;
#(
    parameter int IDX_W   = 16,
    parameter int OFF_W   = 10,
    parameter bit REG_OUT = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_mode,
    input  logic [2*IDX_W-1:0] in_companion,
    input  logic [OFF_W-1:0]   in_offset,
    output logic               out_valid,
    output logic [2*IDX_W-1:0] out_ea_index,
    output logic [2*IDX_W-1:0] out_companion
);

    localparam int CW = 2 * IDX_W;

    typedef struct packed {
        logic          valid;
        logic [CW-1:0] ea;
        logic [CW-1:0] comp;
    } result_t;

    logic [IDX_W-1:0] cur_idx;
    logic [IDX_W-1:0] hi_field;
    logic [IDX_W-1:0] br_next;
    logic [IDX_W-1:0] cw_next;
    ptr_mode_e        mode;

    result_t res_d;
    result_t res_q;

    assign cur_idx  = in_companion[IDX_W-1:0];
    assign hi_field = in_companion[CW-1:IDX_W];
    assign mode     = ptr_mode_e'(in_mode);

    ptr_bitrev_adder #(.IDX_W(IDX_W)) u_bitrev (
        .idx      (cur_idx),
        .step     (hi_field),
        .idx_next (br_next)
    );

    ptr_circ_wrap #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_circ (
        .idx      (cur_idx),
        .len      (hi_field),
        .off      (in_offset),
        .idx_next (cw_next)
    );

    always_comb begin
        res_d       = '0;
        res_d.valid = in_valid;
        res_d.ea    = {{IDX_W{1'b0}}, cur_idx};
        unique case (mode)
            MODE_BITREV: res_d.comp = {hi_field, br_next};
            MODE_CIRC:   res_d.comp = {hi_field, cw_next};
            default:     res_d.comp = in_companion;
        endcase
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                res_q <= '0;
            end else begin
                res_q <= res_d;
            end
        end
    end else begin : g_comb
        assign res_q = res_d;
    end

    assign out_valid     = res_q.valid;
    assign out_ea_index  = res_q.ea;
    assign out_companion = res_q.comp;

endmodule

// File: rtl/ptr_index_update_chk.sv
module ptr_index_update_chk #(
    parameter int IDX_W   = 16,
    parameter int OFF_W   = 10,
    parameter bit REG_OUT = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic               in_mode,
    input logic [2*IDX_W-1:0] in_companion,
    input logic [OFF_W-1:0]   in_offset,
    input logic               out_valid,
    input logic [2*IDX_W-1:0] out_ea_index,
    input logic [2*IDX_W-1:0] out_companion
);

    localparam int CW = 2 * IDX_W;

    // request as seen by the current output, aligned to the output stage
    logic          v_a;
    logic          m_a;
    logic [CW-1:0] c_a;

    if (REG_OUT) begin : g_align
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_a <= 1'b0;
                m_a <= 1'b0;
                c_a <= '0;
            end else begin
                v_a <= in_valid;
                m_a <= in_mode;
                c_a <= in_companion;
            end
        end
    end else begin : g_align
        assign v_a = in_valid;
        assign m_a = in_mode;
        assign c_a = in_companion;
    end

    logic [IDX_W-1:0] len_a;
    logic [IDX_W-1:0] idx_a;
    assign len_a = c_a[CW-1:IDX_W];
    assign idx_a = c_a[IDX_W-1:0];

    p_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == v_a);

    p_ea_r2: assert property (@(posedge clk) disable iff (!rst_n)
        v_a |-> out_ea_index == {{IDX_W{1'b0}}, idx_a});

    p_step_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (v_a && !m_a) |-> out_companion[CW-1:IDX_W] == len_a);

    p_len_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (v_a && m_a) |-> out_companion[CW-1:IDX_W] == len_a);

    // an in-range index with a length larger than any offset stays in range (R6/R7)
    p_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (v_a && m_a && len_a >= IDX_W'(1 << OFF_W) && idx_a < len_a)
            |-> out_companion[IDX_W-1:0] < len_a);

endmodule

bind ptr_index_update ptr_index_update_chk #(
    .IDX_W(IDX_W), .OFF_W(OFF_W), .REG_OUT(REG_OUT)
) u_chk (.*);

// File: tb/tb_ptr_index_update.sv
module tb_ptr_index_update;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_mode = 1'b0;
    logic [31:0] in_companion = '0;
    logic [9:0]  in_offset = '0;
    logic        out_valid;
    logic [31:0] out_ea_index;
    logic [31:0] out_companion;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptr_index_update dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
        .in_companion(in_companion), .in_offset(in_offset),
        .out_valid(out_valid), .out_ea_index(out_ea_index),
        .out_companion(out_companion)
    );

    function automatic logic [15:0] mirror(input logic [15:0] x);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = x[15-i];
        return r;
    endfunction

    function automatic logic [15:0] m_bitrev(input logic [15:0] idx, input logic [15:0] step);
        logic [15:0] s;
        s = mirror(idx) + mirror(step);
        return mirror(s);
    endfunction

    function automatic logic [15:0] m_circ(input logic [15:0] idx, input logic [15:0] len,
                                          input logic [9:0] off);
        int s;
        s = int'(idx) + int'($signed(off));
        if (len != 0) begin
            if (s < 0) s = s + int'(len);
            else if (s >= int'(len)) s = s - int'(len);
        end
        return s[15:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one request at a falling edge, sample one clock later at a falling edge
    task automatic apply(input logic mode, input logic [15:0] hi, input logic [15:0] idx,
                         input logic [9:0] off);
        @(negedge clk);
        in_valid     = 1'b1;
        in_mode      = mode;
        in_companion = {hi, idx};
        in_offset    = off;
        @(negedge clk);
        in_valid     = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", {31'd0, out_valid}, 32'd0);
        check("R1 companion in reset", out_companion, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 valid after reset", {31'd0, out_valid}, 32'd0);
        check("R1 ea after reset", out_ea_index, 32'd0);
    endtask

    task automatic t_bitrev_walk();
        logic [15:0] idx = 16'h0000;
        for (int k = 0; k < 8; k++) begin
            apply(1'b0, 16'h8000, idx, 10'd0);
            check("R10 valid", {31'd0, out_valid}, 32'd1);
            check("R2 ea bitrev", out_ea_index, {16'd0, idx});
            check("R3 walk", {16'd0, out_companion[15:0]}, {16'd0, m_bitrev(idx, 16'h8000)});
            check("R4 step kept", {16'd0, out_companion[31:16]}, 32'h8000);
            idx = out_companion[15:0];
        end
        apply(1'b0, 16'h8000, 16'hFFFF, 10'd0);
        check("R3 carry out of top", {16'd0, out_companion[15:0]}, 32'd0);
    endtask

    task automatic t_bitrev_random();
        for (int k = 0; k < 40; k++) begin
            logic [15:0] idx = 16'($urandom);
            logic [15:0] st  = 16'($urandom);
            apply(1'b0, st, idx, 10'($urandom));
            check("R3 random", {16'd0, out_companion[15:0]}, {16'd0, m_bitrev(idx, st)});
            check("R4 random", {16'd0, out_companion[31:16]}, {16'd0, st});
        end
    endtask

    task automatic run_circ(input string req, input logic [15:0] len, input logic [15:0] idx,
                            input logic [9:0] off);
        apply(1'b1, len, idx, off);
        check(req, {16'd0, out_companion[15:0]}, {16'd0, m_circ(idx, len, off)});
        check("R9 length kept", {16'd0, out_companion[31:16]}, {16'd0, len});
        check("R2 ea circular", out_ea_index, {16'd0, idx});
    endtask

    task automatic t_circ_inrange();
        run_circ("R5 forward", 16'd100, 16'd10, 10'd5);
        run_circ("R5 backward", 16'd100, 16'd10, 10'h3FB);
        run_circ("R5 to zero", 16'd100, 16'd5, 10'h3FB);
        run_circ("R5 to last", 16'd100, 16'd95, 10'd4);
        check("R5 value", {16'd0, out_companion[15:0]}, 32'd99);
    endtask

    task automatic t_circ_high();
        run_circ("R6 exact length", 16'd100, 16'd95, 10'd5);
        check("R6 value", {16'd0, out_companion[15:0]}, 32'd0);
        run_circ("R6 past length", 16'd100, 16'd98, 10'd5);
        check("R6 value past", {16'd0, out_companion[15:0]}, 32'd3);
        run_circ("R6 max offset", 16'd600, 16'd500, 10'd511);
    endtask

    task automatic t_circ_neg();
        run_circ("R7 minus one", 16'd100, 16'd0, 10'h3FF);
        check("R7 value", {16'd0, out_companion[15:0]}, 32'd99);
        run_circ("R7 min offset", 16'd600, 16'd3, 10'h200);
        check("R7 value min", {16'd0, out_companion[15:0]}, 32'd91);
    endtask

    task automatic t_circ_zero_len();
        run_circ("R8 overflow", 16'd0, 16'hFFFE, 10'd5);
        check("R8 value", {16'd0, out_companion[15:0]}, 32'h0003);
        run_circ("R8 underflow", 16'd0, 16'd3, 10'h3FB);
        check("R8 value neg", {16'd0, out_companion[15:0]}, 32'hFFFE);
    endtask

    task automatic t_latency();
        @(negedge clk);
        in_valid = 1'b0;
        in_mode  = 1'b1;
        in_companion = {16'd50, 16'd7};
        @(negedge clk);
        check("R10 idle valid", {31'd0, out_valid}, 32'd0);
        check("R10 idle data", out_ea_index, 32'd7);
    endtask

    initial begin
        t_reset();
        t_bitrev_walk();
        t_bitrev_random();
        t_circ_inrange();
        t_circ_high();
        t_circ_neg();
        t_circ_zero_len();
        t_latency();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule